// File: doc/BRIEF.md
# Dual-Mode SPI Clock Divider

This block derives the serial clock of an SPI shift engine from the module clock. It offers two division laws, and a mode bit in a 13-bit configuration word chooses between them. Linear mode divides by an even factor that an 8-bit field sets. Power-of-two mode divides by a power of two that a 4-bit exponent sets. The block has two registered outputs: a half-period tick, which pulses once per SCLK half period so the shift engine can time its launch and capture edges, and a serial clock with a 50% duty cycle, which toggles on every tick.

The shift engine raises `run_i` for the whole length of a burst. While `run_i` is low, the divider counter stays cleared and the outputs stay low. The first edge of a burst therefore comes a fixed number of cycles after start. A new configuration word is taken at once while the block is idle. During a burst it is taken only when a full SCLK period ends, so a divisor change never produces a shortened pulse. The module clock must run at least twice as fast as SCLK, and the fastest setting gives exactly that ratio.

Top module: `spi_sclk_divider`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `half_tick_o` and `sclk_o` are low.
- R2: When `run_i` is sampled low, the counter clears and both outputs are low after that clock edge. They stay low for as long as `run_i` stays low.
- R3: When configuration bit 12 is 1 (linear mode), the half period H is (bits 7:0) + 1 module cycles. Ticks are exactly H cycles apart, and the SCLK period is 2·H cycles, covering every field value from 0 to 255.
- R4: When bit 12 is 0 (power-of-two mode), the exponent E in bits 11:8 gives an SCLK period of 2^E cycles for E from 1 to 15. The half period is then H = 2^(E-1).
- R5: An exponent of 0 behaves like an exponent of 1: the tick is high in every cycle of a burst, and SCLK toggles every cycle. This is the fastest rate, one half of the module clock.
- R6: `sclk_o` changes only together with a tick. It rises at the first tick of a burst, then alternates, and holds a constant level for the H cycles between ticks (50% duty).
- R7: The configuration word must be stable for one cycle before `run_i` rises. The first tick is then visible after the H-th rising edge at which `run_i` is sampled high.
- R8: A configuration change made during a burst takes effect only at the tick where `sclk_o` falls, which ends a full period. The period in progress, in either half, completes with its old length.
- R9: The field of the mode that is not selected has no effect on the tick spacing. This applies to the exponent in linear mode and to the linear field in power-of-two mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | High for the length of a burst; low holds the divider cleared |
| cfg_i | input | 13 | Configuration word: bit 12 mode (1 = linear), bits 11:8 exponent, bits 7:0 linear field |
| half_tick_o | output | 1 | One-cycle pulse at every SCLK half-period boundary |
| sclk_o | output | 1 | Divided serial clock, idle low, 50% duty |

## Verification
Linear settings at the field extremes 0 and 255 show that the +1 offset is applied and that the counter has full width. Exponents 0, 1, 3 and 15 distinguish the special case at zero, the shift law and the widest count. Each burst measures the first-tick latency and two further tick gaps, together with the SCLK level between ticks, so a wrong start offset, an unequal duty or a wrong law shows up separately. Mid-burst updates issued in the high half and in the low half, plus runs that change only the unused field, confirm that updates happen only at period boundaries and that the unused field is ignored. A batch of random configurations mixes both modes.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  localparam int LIN_W  = 8;
  localparam int EXP_W  = 4;
  localparam int CFG_W  = LIN_W + EXP_W + 1;
  localparam int POW_N  = 1 << EXP_W;
  localparam int HALF_W = ((POW_N - 1) > (LIN_W + 1)) ? (POW_N - 1) : (LIN_W + 1);

  // Packed so that mode is bit 12, exponent bits 11:8, linear field bits 7:0.
  typedef struct packed {
    logic             lin_mode;
    logic [EXP_W-1:0] expo;
    logic [LIN_W-1:0] lin;
  } div_cfg_t;

  typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/spi_div_decode.sv
module spi_div_decode
  import spi_div_pkg::*;
(
  input  div_cfg_t cfg,
  output half_t    half
);
  half_t pow_tab [POW_N];

  // Exponent 0 folds onto exponent 1: the divider cannot go below two cycles per period.
  for (genvar k = 0; k < POW_N; k++) begin : g_pow
    if (k == 0) begin : g_zero
      assign pow_tab[k] = half_t'(1);
    end else begin : g_shift
      assign pow_tab[k] = half_t'(1) << (k - 1);
    end
  end

  always_comb begin
    if (cfg.lin_mode) half = half_t'(cfg.lin) + half_t'(1);
    else              half = pow_tab[cfg.expo];
  end
endmodule

// File: rtl/spi_div_shadow.sv
module spi_div_shadow
  import spi_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  half_t next_half,
  output half_t cur_half
);
  always_ff @(posedge clk) begin
    if (rst)       cur_half <= half_t'(1);
    else if (load) cur_half <= next_half;
  end
endmodule

// File: rtl/spi_div_counter.sv
module spi_div_counter
  import spi_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  half_t half,
  output logic  tick,
  output logic  sclk,
  output logic  period_end
);
  half_t cnt;
  logic  wrap;

  assign wrap       = (cnt == half_t'(half - half_t'(1)));
  assign period_end = run && wrap && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      tick <= 1'b1;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + half_t'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spi_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             half_tick_o,
  output logic             sclk_o
);
  div_cfg_t cfg_s;
  half_t    half_req;
  half_t    half_active;
  logic     period_end;
  logic     load;

  assign cfg_s = cfg_i;
  // Idle: follow the request. Busy: only at the end of a full period.
  assign load  = !run_i || period_end;

  spi_div_decode u_decode (
    .cfg  (cfg_s),
    .half (half_req)
  );

  spi_div_shadow u_shadow (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .next_half (half_req),
    .cur_half  (half_active)
  );

  spi_div_counter u_counter (
    .clk        (clk),
    .rst        (rst),
    .run        (run_i),
    .half       (half_active),
    .tick       (half_tick_o),
    .sclk       (sclk_o),
    .period_end (period_end)
  );
endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk
  import spi_div_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  run,
  input logic  tick,
  input logic  sclk,
  input half_t active_half
);
  half_t gap;
  half_t half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap    <= '0;
      half_q <= half_t'(1);
    end else begin
      half_q <= active_half;
      if (!run)      gap <= '0;
      else if (tick) gap <= half_t'(1);
      else           gap <= gap + half_t'(1);
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!tick && !sclk));

  assert_sclk_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(sclk)) |-> tick);

  // Covers R3 and R4: spacing equals the half length in force.
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap == half_q));

  assert_boundary_update_R8: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(active_half)) |-> (tick && !sclk));

  assert_unit_half_R5: assert property (@(posedge clk) disable iff (rst)
    (run && active_half == half_t'(1)) |=> tick);
endmodule

bind spi_sclk_divider spi_sclk_divider_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .run         (run_i),
  .tick        (half_tick_o),
  .sclk        (sclk_o),
  .active_half (half_active)
);

// File: tb/spi_sclk_divider_tb_top.sv
`timescale 1ns/1ps
module spi_sclk_divider_tb_top;
  localparam int LIMIT = 40000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [12:0] cfg = '0;
  logic        tick;
  logic        sclk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  spi_sclk_divider dut_i (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run),
    .cfg_i       (cfg),
    .half_tick_o (tick),
    .sclk_o      (sclk)
  );

  function automatic int exp_half(logic [12:0] c);
    if (c[12]) return int'(c[7:0]) + 1;
    if (c[11:8] == 4'd0) return 1;
    return 1 << (int'(c[11:8]) - 1);
  endfunction

  function automatic logic [12:0] mk_lin(int lin, int e);
    return {1'b1, 4'(e), 8'(lin)};
  endfunction

  function automatic logic [12:0] mk_pow(int e, int lin);
    return {1'b0, 4'(e), 8'(lin)};
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Counts negedge samples up to and including the next tick; flags any sclk move before it.
  task automatic wait_tick(output int n, output bit steady);
    logic s0;
    s0 = sclk;
    steady = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!tick && sclk != s0) steady = 0;
    end while (!tick && n < LIMIT);
  endtask

  task automatic run_case(logic [12:0] c, string req);
    int h, n;
    bit st;
    h = exp_half(c);
    run = 1'b0;
    cfg = c;
    repeat (3) @(negedge clk);
    run = 1'b1;
    wait_tick(n, st);
    check(n == h, {req, " R7 first tick"}, n, h);
    check(sclk == 1'b1, {req, " R6 rises at first tick"}, sclk, 1);
    wait_tick(n, st);
    check(n == h, {req, " high half"}, n, h);
    check(st && sclk == 1'b0, {req, " R6 high level held"}, sclk, 0);
    wait_tick(n, st);
    check(n == h, {req, " low half"}, n, h);
    check(st && sclk == 1'b1, {req, " R6 low level held"}, sclk, 1);
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    bit st;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!tick && !sclk, "R1 during reset", {tick, sclk}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!tick && !sclk, "R1 after reset", {tick, sclk}, 0);

    // R3 linear extremes and a middle value
    run_case(mk_lin(0, 0), "R3 lin=0");
    run_case(mk_lin(255, 0), "R3 lin=255");
    run_case(mk_lin(6, 0), "R3 lin=6");

    // R4 power-of-two, R5 exponent zero
    run_case(mk_pow(1, 0), "R4 e=1");
    run_case(mk_pow(3, 0), "R4 e=3");
    run_case(mk_pow(15, 0), "R4 e=15");
    run_case(mk_pow(0, 0), "R5 e=0");

    // R9: unused field differs, spacing does not
    run_case(mk_lin(5, 3), "R9 lin mode exp=3");
    run_case(mk_lin(5, 9), "R9 lin mode exp=9");
    run_case(mk_pow(3, 200), "R9 pow mode lin=200");

    // R2: drop run mid-burst while sclk is high
    cfg = mk_lin(4, 0);
    repeat (2) @(negedge clk);
    run = 1'b1;
    wait_tick(n, st);
    check(sclk == 1'b1, "R2 setup sclk high", sclk, 1);
    run = 1'b0;
    @(negedge clk);
    check(!tick && !sclk, "R2 outputs low after stop", {tick, sclk}, 0);
    st = 1;
    repeat (12) begin
      @(negedge clk);
      if (tick || sclk) st = 0;
    end
    check(st, "R2 quiet while idle", st, 1);

    // R8: update in high half, then in low half
    cfg = mk_lin(2, 0);
    repeat (2) @(negedge clk);
    run = 1'b1;
    wait_tick(n, st);
    check(n == 3, "R8 first tick old cfg", n, 3);
    cfg = mk_lin(4, 0);
    wait_tick(n, st);
    check(n == 3 && sclk == 1'b0, "R8 high-half change waits", n, 3);
    cfg = mk_lin(1, 0);
    wait_tick(n, st);
    check(n == 5, "R8 new cfg after boundary", n, 5);
    wait_tick(n, st);
    check(n == 5, "R8 low-half change waits", n, 5);
    wait_tick(n, st);
    check(n == 2, "R8 second change applied", n, 2);
    run = 1'b0;
    @(negedge clk);

    // Random mix of both modes (R3, R4)
    for (int i = 0; i < 16; i++) begin
      logic [12:0] c;
      c = 13'($urandom);
      if (!c[12]) c[11:8] = 4'($urandom_range(0, 9));
      run_case(c, c[12] ? "R3 random" : "R4 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule